// File: doc/BRIEF.md
# Converter Target on a Two-Wire Serial Bus

This block is the bus-facing logic of a 12-bit converter attached to an I2C bus as a target. It oversamples SCL and SDA in the system clock. It finds Start, Repeated Start and Stop conditions and matches a 7-bit device address. It answers by pulling SDA low through an open-drain enable.

A write transaction loads a 6-bit configuration word. That word selects the input routing and the converter mode. A Stop that ends any successfully addressed transaction launches a conversion. The conversion is modelled as a busy period of a set number of clocks. At the end of that period a sample is latched from an input port. While the conversion runs, the device does not answer its address. A read transaction returns the latest result in two bytes, and the host may switch from reading to writing with a Repeated Start.

Top module: `adc_bus_target`

## Requirements
- R1: After the synchronous reset, `sda_pull_o`, `busy_o` and `sleep_o` are low and `cfg_o` is zero.
- R2: The device pulls SDA low during the ninth clock of the address byte only when the seven address bits equal `DEV_ADDR`. After any other address it leaves SDA released until the next Start.
- R3: In a write, the first six data bits are taken on rising SCL edges in this order: bit 5 single/differential, bit 4 odd/sign, bits 3:2 channel select, bit 1 unipolar, bit 0 sleep. Bits 7 and 8 of the byte are ignored, and every written byte is acknowledged.
- R4: A Stop that follows a successful addressing, for either direction, raises `busy_o` for exactly `CONV_CYCLES` clocks. No other event raises `busy_o`.
- R5: While `busy_o` is high, the device does not acknowledge its address.
- R6: A read returns the 12-bit result MSB first, followed by four zero bits, over two bytes.
- R7: The SDA drive changes only while SCL is low. The new data bit follows a falling SCL edge, so SDA is stable through each high phase.
- R8: A read returns the value that `conv_data_i` held when the most recent conversion ended. It is not affected by later changes on that port.
- R9: A write addressed through a Repeated Start directly after a read updates the configuration and counts as addressing for the next Stop.
- R10: While the sleep bit (`cfg_o[0]`) is set, a Stop starts no conversion. `sleep_o` stays high until a later write clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| conv_data_i | input | RES_W | Sample value latched when a conversion ends |
| cfg_o | output | CFG_W | Current configuration word |
| busy_o | output | 1 | Conversion in progress |
| sleep_o | output | 1 | Sleep bit of the configuration |

## Verification
A wrong bit count or a wrong state in the bus engine shows up on `sda_pull_o` within one byte. It appears as a missing or misplaced acknowledge, or as a shifted read frame. A lost addressing flag shows up within three clocks of the Stop, as a `busy_o` that fails to rise. A wrong timer load shows up as a busy window of the wrong length. A result latched at the wrong moment appears only at the next read, because the read data compares against the port value held when the conversion ended.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } bus_st_e;

  localparam int SLEEP_BIT = 0;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/bus_sense.sv
module bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int M = STAGES - 1;

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh    <= '1;
      sda_sh    <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      scl_lvl   <= 1'b1;
      sda_lvl   <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_evt <= 1'b0;
      stop_evt  <= 1'b0;
    end else begin
      scl_sh    <= {scl_sh[M-1:0], scl_i};
      sda_sh    <= {sda_sh[M-1:0], sda_i};
      scl_d     <= scl_sh[M];
      sda_d     <= sda_sh[M];
      scl_lvl   <= scl_sh[M];
      sda_lvl   <= sda_sh[M];
      scl_rise  <= ~scl_d & scl_sh[M];
      scl_fall  <= scl_d & ~scl_sh[M];
      start_evt <= scl_d & scl_sh[M] & sda_d & ~sda_sh[M];
      stop_evt  <= scl_d & scl_sh[M] & ~sda_d & sda_sh[M];
    end
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CYCLES = 400,
  parameter int RES_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [RES_W-1:0] sample,
  output logic             busy,
  output logic [RES_W-1:0] result
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      result <= '0;
    end else if (go && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        busy   <= 1'b0;
        result <= sample;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_engine.sv
module bus_engine
  import adc_bus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         CFG_W    = 6,
  parameter int         RES_W    = 12,
  parameter int         FRAME_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_lvl,
  input  logic             busy,
  input  logic [RES_W-1:0] result,
  output logic             sda_pull,
  output logic [CFG_W-1:0] cfg,
  output logic             conv_go
);
  localparam int         PAD_W    = FRAME_W - RES_W;
  localparam logic [3:0] CFG_LAST = 4'(CFG_W - 1);
  localparam logic [3:0] BYTE_END = 4'(BYTE_BITS);

  bus_st_e              st;
  logic [3:0]           bit_cnt;
  logic [7:0]           rx;
  logic [FRAME_W-1:0]   tx;
  logic                 is_read;
  logic                 hit;
  logic [7:0]           rx_next;

  assign rx_next = {rx[6:0], sda_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      rx       <= '0;
      tx       <= '0;
      is_read  <= 1'b0;
      hit      <= 1'b0;
      sda_pull <= 1'b0;
      cfg      <= '0;
      conv_go  <= 1'b0;
    end else begin
      conv_go <= 1'b0;
      if (stop_evt) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
        hit      <= 1'b0;
        if (hit && !cfg[SLEEP_BIT]) conv_go <= 1'b1;
      end else if (start_evt) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              rx      <= rx_next;
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == BYTE_END) begin
              if (rx[7:1] == DEV_ADDR && !busy) begin
                st       <= ST_AACK;
                sda_pull <= 1'b1;
                hit      <= 1'b1;
                is_read  <= rx[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                st       <= ST_RBYTE;
                tx       <= {result, {PAD_W{1'b0}}};
                sda_pull <= ~result[RES_W-1];
              end else begin
                st       <= ST_WBYTE;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_WBYTE: begin
            if (scl_rise) begin
              rx      <= rx_next;
              bit_cnt <= bit_cnt + 4'd1;
              if (bit_cnt == CFG_LAST) cfg <= rx_next[CFG_W-1:0];
            end else if (scl_fall && bit_cnt == BYTE_END) begin
              st       <= ST_WACK;
              sda_pull <= 1'b1;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              st       <= ST_WBYTE;
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
            end
          end
          ST_RBYTE: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              tx <= {tx[FRAME_W-2:0], 1'b0};
              if (bit_cnt == BYTE_END) begin
                st       <= ST_RACK;
                sda_pull <= 1'b0;
              end else begin
                sda_pull <= ~tx[FRAME_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_lvl) st <= ST_IDLE;
            end else if (scl_fall) begin
              st       <= ST_RBYTE;
              bit_cnt  <= '0;
              sda_pull <= ~tx[FRAME_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_bus_target.sv
module adc_bus_target
  import adc_bus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         RES_W       = 12,
  parameter int         FRAME_W     = 16,
  parameter int         CFG_W       = 6,
  parameter int         CONV_CYCLES = 400,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [RES_W-1:0] conv_data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             busy_o,
  output logic             sleep_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic conv_go;
  logic [RES_W-1:0] result;

  bus_sense #(.STAGES(SYNC_STAGES)) sense_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  bus_engine #(
    .DEV_ADDR(DEV_ADDR), .CFG_W(CFG_W), .RES_W(RES_W), .FRAME_W(FRAME_W)
  ) engine_i (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_lvl(sda_lvl), .busy(busy_o), .result(result),
    .sda_pull(sda_pull_o), .cfg(cfg_o), .conv_go(conv_go)
  );

  conv_timer #(.CYCLES(CONV_CYCLES), .RES_W(RES_W)) timer_i (
    .clk(clk), .rst(rst), .go(conv_go), .sample(conv_data_i),
    .busy(busy_o), .result(result)
  );

  assign sleep_o = cfg_o[SLEEP_BIT];
endmodule

// File: rtl/adc_bus_target_chk.sv
module adc_bus_target_chk #(
  parameter int CONV_CYCLES = 400
) (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic sda_pull_o,
  input logic sleep_o,
  input logic scl_lvl,
  input logic start_evt,
  input logic stop_evt
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= 0;
    else     busy_run <= busy_o ? busy_run + 1 : 0;
  end

  // R4
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(stop_evt, 2));

  // R4
  busy_length_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> busy_run < CONV_CYCLES);

  // R5
  no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !sda_pull_o);

  // R7
  drive_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> (!scl_lvl || $past(start_evt) || $past(stop_evt)));

  // R10
  sleep_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !sleep_o);
endmodule

bind adc_bus_target adc_bus_target_chk #(.CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .busy_o(busy_o), .sda_pull_o(sda_pull_o),
  .sleep_o(sleep_o), .scl_lvl(scl_lvl), .start_evt(start_evt),
  .stop_evt(stop_evt)
);

// File: tb/adc_bus_target_test.sv
module adc_bus_target_test;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int CONV = 400;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [11:0] conv_data = 12'h000;
  logic sda_pull_o, busy_o, sleep_o;
  logic [5:0] cfg_o;
  logic sda_line;

  int errors = 0;
  int checks = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;
  logic [5:0] exp_cfg = 6'd0;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull_o;

  adc_bus_target #(.DEV_ADDR(ADDR), .CONV_CYCLES(CONV)) uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .conv_data_i(conv_data),
    .cfg_o(cfg_o), .busy_o(busy_o), .sleep_o(sleep_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model of configuration, compared every clock while the bus rests
  always @(negedge clk) begin
    if (quiet && !rst && !done) begin
      checks++;
      if (cfg_o !== exp_cfg || sleep_o !== exp_cfg[0]) begin
        errors++;
        $display("FAIL R3/R10 cfg: actual %0h expected %0h", cfg_o, exp_cfg);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
  endtask

  task automatic bus_restart();
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(H);
    end
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H / 2);
    acked = (sda_line == 1'b0);
    wt(H / 2); m_scl = 1'b0; wt(H);
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    logic s1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); m_scl = 1'b1; wt(2);
      s1 = sda_line;
      wt(H - 2);
      b[i] = sda_line;
      // R7: data stable through the high phase
      chk(s1 == b[i], "R7 stable high", int'(b[i]), int'(s1));
      m_scl = 1'b0;
    end
    wt(H / 2); m_sda = nack; wt(H / 2); m_scl = 1'b1; wt(H); m_scl = 1'b0;
    m_sda = 1'b1; wt(H);
  endtask

  task automatic read_word(input bit first_restart, output logic [15:0] w, output bit acked);
    logic [7:0] hi, lo;
    if (first_restart) bus_restart(); else bus_start();
    put_byte({ADDR, 1'b1}, acked);
    w = 16'hxxxx;
    if (acked) begin
      get_byte(1'b0, hi);
      get_byte(1'b1, lo);
      w = {hi, lo};
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < CONV + 50 && busy_o; i++) @(negedge clk);
  endtask

  task automatic settle(input logic [5:0] c);
    wt(3); exp_cfg = c; quiet = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [15:0] w;
    int len;
    wt(4); rst = 1'b0; wt(2);
    // R1 reset state
    chk(sda_pull_o == 1'b0, "R1 sda", sda_pull_o, 0);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(cfg_o == 6'd0 && sleep_o == 1'b0, "R1 cfg", cfg_o, 0);
    quiet = 1'b1;

    // R2 wrong address is not acknowledged
    bus_start(); put_byte({7'h15, 1'b0}, ack);
    chk(!ack, "R2 wrong addr", ack, 0);
    put_byte(8'hFF, ack);
    chk(!ack, "R2 ignored after miss", ack, 0);
    bus_stop(); wt(10);
    chk(busy_o == 1'b0, "R4 no conv after miss", busy_o, 0);

    // R3 write configuration, R4 stop starts conversion
    conv_data = 12'hA5C;
    quiet = 1'b0;
    bus_start(); put_byte({ADDR, 1'b0}, ack);
    chk(ack, "R2 addr ack", ack, 1);
    put_byte({6'b101100, 2'b11}, ack);
    chk(ack, "R3 data ack", ack, 1);
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1;
    len = 0;
    for (int i = 0; i < 20 && !busy_o; i++) @(negedge clk);
    while (busy_o && len < CONV + 20) begin len++; @(negedge clk); end
    chk(len == CONV, "R4 busy length", len, CONV);
    settle(6'b101100);
    chk(cfg_o == 6'b101100, "R3 cfg", cfg_o, 6'b101100);

    // R6 R8 read returns completed result with zero tail
    conv_data = 12'h777;
    read_word(1'b0, w, ack);
    chk(ack, "R2 read addr ack", ack, 1);
    chk(w == {12'hA5C, 4'h0}, "R6 R8 frame", w, {12'hA5C, 4'h0});
    // R8 repeated read without stop returns the same value
    read_word(1'b1, w, ack);
    chk(w == {12'hA5C, 4'h0}, "R8 repeat", w, {12'hA5C, 4'h0});

    // R9 write after read by repeated start
    quiet = 1'b0;
    bus_restart(); put_byte({ADDR, 1'b0}, ack);
    chk(ack, "R9 addr ack", ack, 1);
    put_byte({6'b010110, 2'b00}, ack);
    bus_stop();
    wt(4);
    chk(busy_o == 1'b1, "R9 conv after restart write", busy_o, 1);
    settle(6'b010110);
    // R5 address refused while busy
    bus_start(); put_byte({ADDR, 1'b1}, ack);
    chk(!ack, "R5 nak busy", ack, 0);
    bus_stop();
    wait_idle(); wt(2);
    chk(busy_o == 1'b0, "R4 busy ends", busy_o, 0);
    read_word(1'b0, w, ack);
    chk(w == {12'h777, 4'h0}, "R8 newest", w, {12'h777, 4'h0});
    chk(w[3:0] == 4'h0, "R6 zero tail", w[3:0], 0);
    conv_data = 12'h3F1;
    bus_stop(); wt(4);
    chk(busy_o == 1'b1, "R4 read stop starts", busy_o, 1);
    wait_idle(); wt(2);

    // R10 sleep
    quiet = 1'b0;
    bus_start(); put_byte({ADDR, 1'b0}, ack); put_byte({6'b000011, 2'b00}, ack);
    bus_stop(); wt(10);
    chk(busy_o == 1'b0, "R10 no conv asleep", busy_o, 0);
    chk(sleep_o == 1'b1, "R10 sleep flag", sleep_o, 1);
    settle(6'b000011);
    read_word(1'b0, w, ack);
    chk(w == {12'h3F1, 4'h0}, "R8 after sleep", w, {12'h3F1, 4'h0});
    bus_stop(); wt(10);
    chk(busy_o == 1'b0, "R10 read stop asleep", busy_o, 0);
    chk(sleep_o == 1'b1, "R10 flag held", sleep_o, 1);
    quiet = 1'b0;
    bus_start(); put_byte({ADDR, 1'b0}, ack); put_byte({6'b000010, 2'b00}, ack);
    bus_stop(); wt(4);
    chk(sleep_o == 1'b0, "R10 wake", sleep_o, 0);
    chk(busy_o == 1'b1, "R10 conv after wake", busy_o, 1);
    settle(6'b000010);
    wait_idle(); wt(4);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule